// File: doc/BRIEF.md
# Channel Byte Match Interrupt Unit

This unit sits behind a serial time-division deserializer and turns the arrival of a particular data value in a particular channel into a processor interrupt. The deserializer gives it a strobe, the index of the channel that has just finished and that channel's byte. The unit has two interrupt sources, each set up with its own channel number, its own match byte and its own enable.

When the channel a source is watching comes by, its byte is latched into that source's image register. One cycle later the image register is compared with the source's match byte, and if they are equal the source's pending flag is set. The image register is readable, so the interrupt handler can see the byte that caused the interrupt. The interrupt request stays high while any enabled source is pending.

The unit supplies its own vector. The vector is a programmable base value whose least significant bit names the source being serviced. Source 0 is served before source 1. An acknowledge clears only the pending flag of the source named in the vector.

Top module: `chanMatchIrq`

## Requirements
- R1: When byteValid is high at a clock edge and byteChan equals a source's channel select, byteData is stored in that source's image register and is visible from the next cycle. An image register holds its value at every other edge.
- R2: The two sources work independently, each with its own select, match byte and enable. A byte whose channel equals both selects is captured by both sources.
- R3: At the clock edge that follows a capture, a source's pending flag is set if its image register equals its match byte. An image that equals the match byte sets no flag unless it has just been captured.
- R4: A source whose enable bit is low at the compare edge does not set its pending flag.
- R5: irqOut is high exactly when some source has both its pending flag and its enable bit set.
- R6: vectorOut bits above bit 0 equal the same bits of vectorBase, and vectorBase bit 0 is ignored. vectorOut bit 0 is 0 when source 0 is pending and enabled. Otherwise it is 1, so source 0 takes priority when both sources request.
- R7: When intAck is high at a clock edge while irqOut is high, the flag of the source named by vectorOut bit 0 is cleared and the other flag is left unchanged. intAck has no effect while irqOut is low.
- R8: When a source's flag is set and cleared at the same edge, the set wins and the flag stays high.
- R9: After reset, both pending flags are clear, both image registers are zero and irqOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | Strobe from the deserializer: a received channel byte is present |
| byteChan | input | CHAN_W | Index of the channel of the present byte |
| byteData | input | DATA_W | Received channel byte |
| srcEnable | input | 2 | Enable bit per source; bit 0 is source 0 |
| chanSel0 | input | CHAN_W | Channel watched by source 0 |
| chanSel1 | input | CHAN_W | Channel watched by source 1 |
| matchByte0 | input | DATA_W | Match byte of source 0 |
| matchByte1 | input | DATA_W | Match byte of source 1 |
| vectorBase | input | DATA_W | Base value of the interrupt vector |
| intAck | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| irqOut | output | 1 | Interrupt request |
| vectorOut | output | DATA_W | Vector returned during acknowledge |
| pendingOut | output | 2 | Pending flag per source |
| image0 | output | DATA_W | Image register of source 0 |
| image1 | output | DATA_W | Image register of source 1 |

## Verification
The assertions check several rules on every cycle. An image register changes only on a capture and then holds the captured byte. A pending flag rises only when the compare matched and the source was enabled. The vector's upper bits follow the base, and its low bit is 0 whenever source 0 requests. Acknowledging source 0 never clears source 1. Other behaviour depends on the order of events and only the bench's scenarios show it: the exact cycle at which a flag rises, a repeated match byte raising a second interrupt after an acknowledge, the set winning over a clear at the same edge, an acknowledge with nothing pending, and a byte shared by both sources' channel. The bench checks these against its cycle model.

// File: rtl/chanMatchPkg.sv
package chanMatchPkg;
  localparam int NSRC = 2;

  typedef struct packed {
    logic [NSRC-1:0] capture;
    logic            grantId;
  } ctrlStb_t;
endpackage

// File: rtl/matchControl.sv
module matchControl
  import chanMatchPkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        byteValid,
  input  logic [CHAN_W-1:0]           byteChan,
  input  logic [NSRC-1:0][CHAN_W-1:0] chanSel,
  input  logic [NSRC-1:0]             srcEnable,
  input  logic [NSRC-1:0]             matchHit,
  input  logic                        intAck,
  output ctrlStb_t                    stb,
  output logic [NSRC-1:0]             pending,
  output logic                        irqOut
);
  logic [NSRC-1:0] capNow;
  logic [NSRC-1:0] cmpDue;
  logic [NSRC-1:0] setVec;
  logic [NSRC-1:0] clrVec;
  logic [NSRC-1:0] reqVec;
  logic            grantId;

  assign reqVec  = pending & srcEnable;
  assign irqOut  = |reqVec;
  assign grantId = ~reqVec[0];

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : gSrc
      assign capNow[i] = byteValid && (byteChan == chanSel[i]);
      assign setVec[i] = cmpDue[i] && matchHit[i] && srcEnable[i];
      assign clrVec[i] = intAck && irqOut && (grantId == 1'(i));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cmpDue[i]  <= 1'b0;
          pending[i] <= 1'b0;
        end else begin
          cmpDue[i] <= capNow[i];
          if (setVec[i])      pending[i] <= 1'b1;
          else if (clrVec[i]) pending[i] <= 1'b0;
        end
      end

      // R4: a flag only rises if its source was enabled at that edge
      a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pending[i]) |-> $past(srcEnable[i]));

      // R3: a flag only rises after the datapath reported a match
      a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pending[i]) |-> $past(matchHit[i]));
    end
  endgenerate

  // R7: serving source 0 never clears source 1
  a_r7_other_kept: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && pending[0] && srcEnable[0]) |=> !$fell(pending[1]));

  always_comb begin
    stb         = '0;
    stb.capture = capNow;
    stb.grantId = grantId;
  end
endmodule

// File: rtl/matchDatapath.sv
module matchDatapath
  import chanMatchPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [DATA_W-1:0]           byteData,
  input  logic [NSRC-1:0][DATA_W-1:0] matchByte,
  input  logic [DATA_W-1:0]           vectorBase,
  input  ctrlStb_t                    stb,
  output logic [NSRC-1:0][DATA_W-1:0] image,
  output logic [NSRC-1:0]             matchHit,
  output logic [DATA_W-1:0]           vectorOut
);
  localparam logic [DATA_W-1:0] LSB_MASK = DATA_W'(1);

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : gImg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              image[i] <= '0;
        else if (stb.capture[i]) image[i] <= byteData;
      end

      assign matchHit[i] = (image[i] == matchByte[i]);

      // R1: a capture stores the presented byte
      a_r1_capture: assert property (@(posedge clk) disable iff (!rstN)
        $past(stb.capture[i]) |-> (image[i] == $past(byteData)));

      // R1: without a capture the image holds
      a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
        !$past(stb.capture[i]) |-> $stable(image[i]));
    end
  endgenerate

  assign vectorOut = (vectorBase & ~LSB_MASK) | DATA_W'(stb.grantId);
endmodule

// File: rtl/chanMatchIrq.sv
module chanMatchIrq
  import chanMatchPkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [CHAN_W-1:0] byteChan,
  input  logic [DATA_W-1:0] byteData,
  input  logic [1:0]        srcEnable,
  input  logic [CHAN_W-1:0] chanSel0,
  input  logic [CHAN_W-1:0] chanSel1,
  input  logic [DATA_W-1:0] matchByte0,
  input  logic [DATA_W-1:0] matchByte1,
  input  logic [DATA_W-1:0] vectorBase,
  input  logic              intAck,
  output logic              irqOut,
  output logic [DATA_W-1:0] vectorOut,
  output logic [1:0]        pendingOut,
  output logic [DATA_W-1:0] image0,
  output logic [DATA_W-1:0] image1
);
  ctrlStb_t                    stb;
  logic [NSRC-1:0][CHAN_W-1:0] chanSelArr;
  logic [NSRC-1:0][DATA_W-1:0] matchArr;
  logic [NSRC-1:0][DATA_W-1:0] imageArr;
  logic [NSRC-1:0]             matchHit;

  assign chanSelArr = {chanSel1, chanSel0};
  assign matchArr   = {matchByte1, matchByte0};
  assign image0     = imageArr[0];
  assign image1     = imageArr[1];

  matchControl #(.CHAN_W(CHAN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteChan(byteChan),
    .chanSel(chanSelArr), .srcEnable(srcEnable), .matchHit(matchHit),
    .intAck(intAck), .stb(stb), .pending(pendingOut), .irqOut(irqOut)
  );

  matchDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .byteData(byteData), .matchByte(matchArr),
    .vectorBase(vectorBase), .stb(stb), .image(imageArr),
    .matchHit(matchHit), .vectorOut(vectorOut)
  );

  // R6: source 0 wins the vector whenever it requests
  a_r6_priority: assert property (@(posedge clk) disable iff (!rstN)
    (pendingOut[0] && srcEnable[0]) |-> (vectorOut[0] == 1'b0));

  // R6: upper vector bits come from the base
  a_r6_base: assert property (@(posedge clk) disable iff (!rstN)
    vectorOut[DATA_W-1:1] == vectorBase[DATA_W-1:1]);
endmodule

// File: tb/tb_chanMatchIrq.sv
module tb_chanMatchIrq;
  localparam int CW = 5;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          byteValid = 1'b0;
  logic [CW-1:0] byteChan = '0;
  logic [DW-1:0] byteData = '0;
  logic [1:0]    srcEnable = 2'b11;
  logic [CW-1:0] chanSel0 = 5'd3;
  logic [CW-1:0] chanSel1 = 5'd7;
  logic [DW-1:0] matchByte0 = 8'hA5;
  logic [DW-1:0] matchByte1 = 8'h3C;
  logic [DW-1:0] vectorBase = 8'h41;
  logic          intAck = 1'b0;
  logic          irqOut;
  logic [DW-1:0] vectorOut;
  logic [1:0]    pendingOut;
  logic [DW-1:0] image0, image1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // reference state
  logic [DW-1:0] mImg [2];
  logic          mPend [2];
  logic          mCmp [2];

  chanMatchIrq #(.CHAN_W(CW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteChan(byteChan),
    .byteData(byteData), .srcEnable(srcEnable), .chanSel0(chanSel0),
    .chanSel1(chanSel1), .matchByte0(matchByte0), .matchByte1(matchByte1),
    .vectorBase(vectorBase), .intAck(intAck), .irqOut(irqOut),
    .vectorOut(vectorOut), .pendingOut(pendingOut), .image0(image0),
    .image1(image1)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic bit reqOf(int s);
    return mPend[s] && srcEnable[s];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      for (int s = 0; s < 2; s++) begin
        mImg[s] = '0; mPend[s] = 1'b0; mCmp[s] = 1'b0;
      end
    end else begin
      automatic bit anyReq = reqOf(0) || reqOf(1);
      automatic int grant = reqOf(0) ? 0 : 1;
      automatic logic [CW-1:0] sel [2] = '{chanSel0, chanSel1};
      automatic logic [DW-1:0] mat [2] = '{matchByte0, matchByte1};
      for (int s = 0; s < 2; s++) begin
        if (mCmp[s] && mImg[s] == mat[s] && srcEnable[s]) mPend[s] = 1'b1;
        else if (intAck && anyReq && grant == s) mPend[s] = 1'b0;
      end
      for (int s = 0; s < 2; s++) begin
        mCmp[s] = byteValid && byteChan == sel[s];
        if (mCmp[s]) mImg[s] = byteData;
      end
    end
    #3;
    if (!rstN) begin
      check("R9 pending", int'(pendingOut), 0);
      check("R9 irq", int'(irqOut), 0);
      check("R9 image", int'({image1, image0}), 0);
    end else begin
      check("R1,R2 image0", int'(image0), int'(mImg[0]));
      check("R1,R2 image1", int'(image1), int'(mImg[1]));
      check("R3,R4,R7,R8 pending", int'(pendingOut), int'({mPend[1], mPend[0]}));
      check("R5 irq", int'(irqOut), int'(reqOf(0) || reqOf(1)));
      check("R6 vector", int'(vectorOut),
            int'({vectorBase[DW-1:1], reqOf(0) ? 1'b0 : 1'b1}));
    end
  end

  task automatic step(bit v, int ch, int d, bit ack);
    @(negedge clk);
    byteValid = v; byteChan = CW'(ch); byteData = DW'(d); intAck = ack;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    // R1 R3: match on source 0 channel
    step(1, 3, 'hA5, 0); idle(3);
    // R3: non-matching byte on source 1, other channel ignored (R1)
    step(1, 7, 'h11, 0); step(1, 9, 'hEE, 0); idle(2);
    // R6 R5: both pending, source 0 first
    step(1, 7, 'h3C, 0); idle(2);
    step(0, 0, 0, 1); idle(1);   // R7 clears source 0 only
    step(0, 0, 0, 1); idle(2);   // R7 clears source 1
    step(0, 0, 0, 1); idle(1);   // R7 ack without request
    // R3: image still equals match but no new capture
    idle(3);
    // R4: disabled source ignores its match
    srcEnable = 2'b10;
    step(1, 3, 'hA5, 0); idle(3);
    srcEnable = 2'b11; idle(2);
    // R8: set and clear of source 1 at the same edge
    step(1, 7, 'h3C, 0); idle(2);
    step(1, 7, 'h3C, 0); step(0, 0, 0, 1); idle(2);
    step(0, 0, 0, 1); idle(2);
    // R2: one channel watched by both sources
    chanSel1 = 5'd3; matchByte1 = 8'hA5; vectorBase = 8'hC0;
    step(1, 3, 'hA5, 0); idle(2);
    step(0, 0, 0, 1); step(0, 0, 0, 1); idle(2);
    // R2: shared channel, only source 1 matches
    matchByte1 = 8'h5A;
    step(1, 3, 'h5A, 0); idle(2);
    step(0, 0, 0, 1); idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule